// File: doc/BRIEF.md
# Four-Way Result-Select ALU

This block is the combinational arithmetic and logic stage of a small load/store datapath. It takes two operands, `opnd_a` and `opnd_b`, and a shared adder/subtractor works on them at all times. A two-bit result selector then picks one of four values for the output:

- `opnd_b` passed through unchanged, which the datapath uses for load-upper-immediate.
- A set-on-sign value, which is the sign bit of the adder/subtractor output placed in bit 0 of an otherwise zero word.
- The adder/subtractor output.
- The output of a bitwise unit, which `bit_op` steers.

Two flags, overflow and zero, always describe the adder/subtractor output. They do not depend on which value the selector puts on `result`.

The block holds no state and has no clock. A set-less-than instruction is built by driving `sub_en` high with the set-on-sign selection. The caller must accept that the value reported is the raw sign of the wrapped difference.

Top module: `quad_alu`

## Requirements
- R1: When `res_sel` is 2'b00, `result` equals `opnd_b` bit for bit, whatever the other controls are.
- R2: When `res_sel` is 2'b01, `result[31:1]` is zero and `result[0]` equals bit 31 of the adder/subtractor output.
- R3: When `res_sel` is 2'b10 and `sub_en` is 0, `result` is `opnd_a + opnd_b` modulo 2^32.
- R4: When `res_sel` is 2'b10 and `sub_en` is 1, `result` is `opnd_a - opnd_b` modulo 2^32.
- R5: When `res_sel` is 2'b11, `bit_op` 2'b00 gives `opnd_a & opnd_b` and `bit_op` 2'b01 gives `opnd_a | opnd_b`.
- R6: When `res_sel` is 2'b11, `bit_op` 2'b10 gives `opnd_a ^ opnd_b` and `bit_op` 2'b11 gives `~(opnd_a | opnd_b)`.
- R7: `zero` is 1 exactly when the adder/subtractor output is all zeros, for every value of `res_sel` and `bit_op`.
- R8: `ovf` is 1 exactly when the adder/subtractor result overflows as a signed two's-complement operation, for every value of `res_sel`. For an addition this means both operands have the same sign and the sum's sign differs from it. For a subtraction this means the operands differ in sign and the difference's sign differs from `opnd_a`.
- R9: The set-on-sign output takes the sign of the wrapped difference. For 32'h8000_0000 minus 1, with `sub_en` 1 and `res_sel` 2'b01, `result` is 0 and `ovf` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand; passed through on selection 2'b00 |
| res_sel | input | 2 | Result class: 00 pass-through, 01 set-on-sign, 10 arithmetic, 11 bitwise |
| bit_op | input | 2 | Bitwise operation: 00 AND, 01 OR, 10 XOR, 11 NOR |
| sub_en | input | 1 | 0 adds, 1 subtracts `opnd_b` from `opnd_a` |
| result | output | 32 | Selected result |
| ovf | output | 1 | Signed overflow of the adder/subtractor |
| zero | output | 1 | Adder/subtractor output is all zeros |

## Verification
The hardest situation to reach from the ports is a carry that travels across every internal block boundary of the carry-select adder. Cases such as -1 + 1 and 0 - 1 are needed to send a carry or borrow through all 32 bits.

Signed overflow in both directions needs the same kind of targeted values. These include the most negative value minus 1 and the most positive value plus 1, which are also the cases where set-on-sign reports the wrong order. Directed vectors cover these corners under every selector and operation code. A long LFSR-driven run then fills in mixed sign combinations.

// File: rtl/quad_alu_pkg.sv
package quad_alu_pkg;

    localparam int ALU_W_DEF    = 32;
    localparam int CSEL_BLK_DEF = 8;

    typedef enum logic [1:0] {
        RS_PASS_B  = 2'b00,
        RS_SIGN    = 2'b01,
        RS_ARITH   = 2'b10,
        RS_BITWISE = 2'b11
    } res_sel_e;

    typedef enum logic [1:0] {
        BW_AND = 2'b00,
        BW_OR  = 2'b01,
        BW_XOR = 2'b10,
        BW_NOR = 2'b11
    } bw_op_e;

    typedef struct packed {
        logic ovf;
        logic zero;
    } alu_flags_t;

    // Signed overflow: both adder inputs share a sign the sum does not.
    function automatic logic sgn_ovf(input logic a_msb, input logic b_eff_msb,
                                     input logic s_msb);
        return (a_msb == b_eff_msb) && (s_msb != a_msb);
    endfunction

endpackage

// File: rtl/quad_alu_addsub.sv
module quad_alu_addsub
    import quad_alu_pkg::*;
#(
    parameter int W   = ALU_W_DEF,
    parameter int BLK = CSEL_BLK_DEF
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output alu_flags_t   flags
);
    localparam int NB       = (BLK > 0) ? (W / BLK) : 1;
    localparam bit USE_CSEL = (BLK > 0) && (W % BLK == 0) && (NB > 1);

    logic [W-1:0] b_eff;
    assign b_eff = b ^ {W{sub}};

    generate
        if (USE_CSEL) begin : g_csel
            logic [NB-1:0] cy;
            assign cy[0] = sub;
            for (genvar k = 0; k < NB; k++) begin : g_blk
                if (k == NB - 1) begin : g_top
                    logic [BLK-1:0] t0;
                    assign t0 = a[k*BLK +: BLK] + b_eff[k*BLK +: BLK];
                    assign sum[k*BLK +: BLK] = cy[k] ? (t0 + BLK'(1)) : t0;
                end else begin : g_mid
                    logic [BLK:0] s_c0;
                    logic [BLK:0] s_c1;
                    assign s_c0 = {1'b0, a[k*BLK +: BLK]} + {1'b0, b_eff[k*BLK +: BLK]};
                    assign s_c1 = s_c0 + (BLK+1)'(1);
                    assign sum[k*BLK +: BLK] = cy[k] ? s_c1[BLK-1:0] : s_c0[BLK-1:0];
                    assign cy[k+1]           = cy[k] ? s_c1[BLK] : s_c0[BLK];
                end
            end
        end else begin : g_ripple
            assign sum = a + b_eff + W'(sub);
        end
    endgenerate

    assign flags.ovf  = sgn_ovf(a[W-1], b_eff[W-1], sum[W-1]);
    assign flags.zero = ~|sum;

endmodule

// File: rtl/quad_alu_bitwise.sv
module quad_alu_bitwise
    import quad_alu_pkg::*;
#(
    parameter int W = ALU_W_DEF
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  bw_op_e       op,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            BW_AND:  y = a & b;
            BW_OR:   y = a | b;
            BW_XOR:  y = a ^ b;
            BW_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/quad_alu_outmux.sv
module quad_alu_outmux
    import quad_alu_pkg::*;
#(
    parameter int W = ALU_W_DEF
) (
    input  res_sel_e     sel,
    input  logic [W-1:0] pass_b,
    input  logic [W-1:0] arith,
    input  logic [W-1:0] bitwise,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            RS_PASS_B:  y = pass_b;
            RS_SIGN:    y = {{(W-1){1'b0}}, arith[W-1]};
            RS_ARITH:   y = arith;
            RS_BITWISE: y = bitwise;
            default:    y = '0;
        endcase
    end
endmodule

// File: rtl/quad_alu.sv
module quad_alu
    import quad_alu_pkg::*;
#(
    parameter int DATA_W = ALU_W_DEF,
    parameter int BLK_W  = CSEL_BLK_DEF
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [1:0]        res_sel,
    input  logic [1:0]        bit_op,
    input  logic              sub_en,
    output logic [DATA_W-1:0] result,
    output logic              ovf,
    output logic              zero
);
    logic [DATA_W-1:0] arith_y;
    logic [DATA_W-1:0] bw_y;
    alu_flags_t        flg;

    quad_alu_addsub #(.W(DATA_W), .BLK(BLK_W)) u_addsub (
        .a     (opnd_a),
        .b     (opnd_b),
        .sub   (sub_en),
        .sum   (arith_y),
        .flags (flg)
    );

    quad_alu_bitwise #(.W(DATA_W)) u_bitwise (
        .a  (opnd_a),
        .b  (opnd_b),
        .op (bw_op_e'(bit_op)),
        .y  (bw_y)
    );

    quad_alu_outmux #(.W(DATA_W)) u_outmux (
        .sel     (res_sel_e'(res_sel)),
        .pass_b  (opnd_b),
        .arith   (arith_y),
        .bitwise (bw_y),
        .y       (result)
    );

    assign ovf  = flg.ovf;
    assign zero = flg.zero;

endmodule

// File: rtl/quad_alu_chk.sv
module quad_alu_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [1:0]   res_sel,
    input logic [1:0]   bit_op,
    input logic         sub_en,
    input logic [W-1:0] result,
    input logic         ovf,
    input logic         zero
);
    always_comb begin
        // R1
        if (res_sel == 2'b00) pass_b_chk: assert (result == opnd_b);
        // R2
        if (res_sel == 2'b01) sign_upper_chk: assert (result[W-1:1] == '0);
        // R7
        if (res_sel == 2'b10) zero_flag_chk: assert (zero == (result == '0));
        // R8
        if (!sub_en && (opnd_a[W-1] != opnd_b[W-1])) no_overflow_chk: assert (!ovf);
        // R4
        if (sub_en && (opnd_a == opnd_b)) self_sub_chk: assert (zero && !ovf);
        // R6
        if (res_sel == 2'b11 && bit_op == 2'b11) nor_disjoint_chk: assert ((result & (opnd_a | opnd_b)) == '0);
    end
endmodule

bind quad_alu quad_alu_chk #(.W(DATA_W)) i_quad_alu_chk (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .res_sel (res_sel),
    .bit_op  (bit_op),
    .sub_en  (sub_en),
    .result  (result),
    .ovf     (ovf),
    .zero    (zero)
);

// File: tb/test_quad_alu.sv
module test_quad_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [1:0]  res_sel = 2'b00;
    logic [1:0]  bit_op = 2'b00;
    logic        sub_en = 1'b0;
    logic [31:0] result;
    logic        ovf;
    logic        zero;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] res;
        logic        ovf;
        logic        zero;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    quad_alu i_quad_alu (
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .res_sel (res_sel),
        .bit_op  (bit_op),
        .sub_en  (sub_en),
        .result  (result),
        .ovf     (ovf),
        .zero    (zero)
    );

    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic [1:0] sel, input logic [1:0] op,
                                   input logic sub, input string tag);
        exp_t        e;
        logic [31:0] s;
        s      = sub ? (a - b) : (a + b);
        e.tag  = tag;
        e.zero = (s == 32'h0);
        if (sub) e.ovf = (a[31] != b[31]) && (s[31] != a[31]);
        else     e.ovf = (a[31] == b[31]) && (s[31] != a[31]);
        case (sel)
            2'b00: e.res = b;
            2'b01: e.res = {31'h0, s[31]};
            2'b10: e.res = s;
            default: case (op)
                2'b00: e.res = a & b;
                2'b01: e.res = a | b;
                2'b10: e.res = a ^ b;
                default: e.res = ~(a | b);
            endcase
        endcase
        return e;
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] sel, input logic [1:0] op,
                         input logic sub, input string tag);
        @(posedge clk);
        #1;
        opnd_a  = a;
        opnd_b  = b;
        res_sel = sel;
        bit_op  = op;
        sub_en  = sub;
        sb_q.push_back(model(a, b, sel, op, sub, tag));
    endtask

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp(e.tag, result, e.res);
            cmp({e.tag, "/R7 zero"}, {31'h0, zero}, {31'h0, e.zero});
            cmp({e.tag, "/R8 ovf"},  {31'h0, ovf},  {31'h0, e.ovf});
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        // reset state: all-zero inputs give result 0, zero 1, ovf 0 (R1, R7)
        @(negedge clk);
        cmp("reset R1 result", result, 32'h0);
        cmp("reset R7 zero", {31'h0, zero}, 32'h1);
        cmp("reset R8 ovf", {31'h0, ovf}, 32'h0);
        rst = 1'b0;

        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
                for (int u = 0; u < 2; u++) begin
                    drive(32'hF0F0_1234, 32'h0FF0_8765, 2'(s), 2'(o), 1'(u), "R1 R2 R3 R4 R5 R6 sweep");
                    drive(32'h8000_0000, 32'h0000_0001, 2'(s), 2'(o), 1'(u), "R9 R8 edge sweep");
                end

        drive(32'hDEAD_BEEF, 32'h1234_5678, 2'b00, 2'b11, 1'b1, "R1 pass");
        drive(32'h0000_0003, 32'h0000_0007, 2'b01, 2'b00, 1'b1, "R2 3<7");
        drive(32'h0000_0007, 32'h0000_0003, 2'b01, 2'b00, 1'b1, "R2 7>3");
        drive(32'hFFFF_FFFF, 32'h0000_0001, 2'b10, 2'b00, 1'b0, "R3 full carry");
        drive(32'h7FFF_FFFF, 32'h0000_0001, 2'b10, 2'b00, 1'b0, "R3 R8 pos ovf");
        drive(32'h8000_0000, 32'h8000_0000, 2'b10, 2'b00, 1'b0, "R3 R8 neg ovf");
        drive(32'h0000_0000, 32'h0000_0001, 2'b10, 2'b00, 1'b1, "R4 full borrow");
        drive(32'h0000_0005, 32'h0000_0005, 2'b10, 2'b00, 1'b1, "R4 R7 self");
        drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'b10, 2'b00, 1'b1, "R4 R8 sub ovf");
        drive(32'h8000_0000, 32'h0000_0001, 2'b01, 2'b00, 1'b1, "R9 min-1");
        drive(32'hCCCC_CCCC, 32'hAAAA_AAAA, 2'b11, 2'b00, 1'b0, "R5 and");
        drive(32'hCCCC_CCCC, 32'hAAAA_AAAA, 2'b11, 2'b01, 1'b0, "R5 or");
        drive(32'hCCCC_CCCC, 32'hAAAA_AAAA, 2'b11, 2'b10, 1'b0, "R6 xor");
        drive(32'hCCCC_CCCC, 32'hAAAA_AAAA, 2'b11, 2'b11, 1'b0, "R6 nor");
        drive(32'h0000_00FF, 32'h0000_00FF, 2'b11, 2'b10, 1'b1, "R7 zero under bitwise");

        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a  = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            b  = (i % 5 == 0) ? a : lf;
            drive(a, b, lf[1:0], lf[3:2], lf[4], "R1 R2 R3 R4 R5 R6 random");
        end

        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        finish_run();
    end

endmodule